// File: doc/BRIEF.md
# Multi-Stage Sweep Point Sequencer

This block steps a measurement sweep through its points. Each point is measured in one to eight stages, and each stage may excite one of two ports. Two registers are loaded through a simple write strobe. The setup word holds the number of stages, the stage index assigned to each port and a halt-per-stage option. The points register holds the number of sweep points.

A start pulse copies both registers into working copies and clears the point and stage counters. For each stage the block drives the matching port select and pulses a measurement request. It then waits for the measurement-done strobe. When the strobe arrives, it emits a tagged result strobe and moves to the next stage, or to the first stage of the next point.

After the last stage of the last point the block goes idle and raises a completion flag. An abort pulse ends the sweep at once. When halt-per-stage is enabled, the block parks after every stage until it receives a resume pulse.

Top module: `sweep_stage_seq`

## Requirements
- R1: The setup register is written at address 0x6. Its fields are: bits [15:13] hold the stage count minus one; bit 12 enables halt-per-stage; bits [5:3] hold the port-1 stage index; bits [2:0] hold the port-2 stage index. The points register is written at address 0x1, and its bits [12:0] hold the number of points.
- R2: A start pulse in idle clears both counters, so the first tag is stage 0, point 0. The stage counter advances within a point. After the last stage it returns to 0 and the point counter increments.
- R3: Each accepted measurement-done strobe produces `resultValid` for exactly one clock, in the cycle after the strobe is sampled. `resultTag` carries the stage number in bits [15:13] and the point number in bits [12:0] of the measurement just completed.
- R4: A port select is high while the current stage equals that port's stage index. A port whose index is above the last stage is never excited. If both indices are equal, only port 1 is excited, so at most one select is high.
- R5: Both port selects are low while the block is idle or halted.
- R6: `measStart` pulses for one clock at the beginning of every stage measurement.
- R7: After the result of the last stage of the last point, `sweepBusy` drops and `sweepDone` rises in the same cycle. `sweepDone` stays high until the next start. A start with zero points sets `sweepDone` at once and requests no measurement.
- R8: With halt-per-stage set, the block raises `sweepHalted` after every stage except the final one and continues on a resume pulse. A resume pulse outside the halted state has no effect.
- R9: An abort pulse during a sweep makes `sweepBusy` and both selects low on the next cycle. `sweepDone` stays low, and no result is emitted for a pending measurement.
- R10: Register writes made during a sweep do not affect that sweep. They take effect at the next start.
- R11: A start pulse while a sweep is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address |
| regWrData | input | 16 | Register write data |
| startPulse | input | 1 | Begin a sweep (accepted only when idle) |
| abortPulse | input | 1 | Stop the running sweep |
| resumePulse | input | 1 | Continue after a per-stage halt |
| measDone | input | 1 | Measurement-done strobe |
| measStart | output | 1 | One-clock measurement request |
| excitePort1 | output | 1 | Port 1 excitation select |
| excitePort2 | output | 1 | Port 2 excitation select |
| resultValid | output | 1 | One-clock result strobe |
| resultTag | output | 16 | Stage [15:13] and point [12:0] of the result |
| sweepBusy | output | 1 | Sweep in progress (including halted) |
| sweepHalted | output | 1 | Parked after a stage, waiting for resume |
| sweepDone | output | 1 | Last sweep completed normally |

## Verification
The assertions assume that the measurement-done strobe and the resume and abort pulses are sampled in the states that can accept them. They also assume that the register fields describe a sweep whose point count fits the 13-bit counter. The bench raises measurement-done only while a measurement is in flight and lowers it on the first result strobe, so one strobe never completes two stages. It pulses resume only while halted, except in the single directed case where that pulse is meant to be ignored. Abort is applied only after a measurement has been issued.

// File: rtl/sweep_seq_pkg.sv
package sweep_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_HALT} seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearCnt;  // latch working config, zero counters
    logic advance;   // measurement finished: emit tag, step counters
    logic driveEn;   // a stage measurement is in flight
  } seqStrobe_t;
endpackage

// File: rtl/sweep_seq_datapath.sv
module sweep_seq_datapath
  import sweep_seq_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 16,
  parameter int POINT_W     = 13,
  parameter int STAGE_W     = 3,
  parameter int SETUP_ADDR  = 6,
  parameter int POINTS_ADDR = 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       regWrEn,
  input  logic [ADDR_W-1:0]          regAddr,
  input  logic [DATA_W-1:0]          regWrData,
  input  seqStrobe_t                 strobe,
  output logic                       lastStage,
  output logic                       lastPoint,
  output logic                       haltEach,
  output logic                       zeroPoints,
  output logic                       excite1,
  output logic                       excite2,
  output logic                       resultValid,
  output logic [STAGE_W+POINT_W-1:0] resultTag
);
  localparam int HALT_BIT = DATA_W - 1 - STAGE_W;

  logic [DATA_W-1:0]  setupReg, setupAct;
  logic [POINT_W-1:0] pointsReg, pointsAct;
  logic [STAGE_W-1:0] stageCnt;
  logic [POINT_W-1:0] pointCnt;
  logic [STAGE_W-1:0] lastIdx, p1Idx, p2Idx;

  assign lastIdx = setupAct[DATA_W-1 -: STAGE_W];
  assign p1Idx   = setupAct[2*STAGE_W-1 : STAGE_W];
  assign p2Idx   = setupAct[STAGE_W-1 : 0];
  assign haltEach = setupAct[HALT_BIT];

  assign lastStage  = (stageCnt == lastIdx);
  assign lastPoint  = (pointCnt == pointsAct - POINT_W'(1));
  assign zeroPoints = (pointsReg == '0);

  // port 1 wins when both ports name the same stage
  assign excite1 = strobe.driveEn && (stageCnt == p1Idx);
  assign excite2 = strobe.driveEn && (stageCnt == p2Idx) && !(stageCnt == p1Idx);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      setupReg  <= '0;
      pointsReg <= '0;
    end else if (regWrEn) begin
      if (regAddr == ADDR_W'(SETUP_ADDR))  setupReg  <= regWrData;
      if (regAddr == ADDR_W'(POINTS_ADDR)) pointsReg <= regWrData[POINT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      setupAct    <= '0;
      pointsAct   <= '0;
      stageCnt    <= '0;
      pointCnt    <= '0;
      resultValid <= 1'b0;
      resultTag   <= '0;
    end else begin
      resultValid <= strobe.advance;
      if (strobe.clearCnt) begin
        setupAct  <= setupReg;
        pointsAct <= pointsReg;
        stageCnt  <= '0;
        pointCnt  <= '0;
      end else if (strobe.advance) begin
        resultTag <= {stageCnt, pointCnt};
        if (lastStage) begin
          stageCnt <= '0;
          pointCnt <= pointCnt + POINT_W'(1);
        end else begin
          stageCnt <= stageCnt + STAGE_W'(1);
        end
      end
    end
  end

  // R3: result strobe never lasts two cycles
  a_r3_valid_single: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);
  // R3: a tagged point lies inside the configured range
  a_r3_point_in_range: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (resultTag[POINT_W-1:0] < pointsAct));
  // R2: stage counter never passes the last configured stage
  a_r2_stage_bound: assert property (@(posedge clk) disable iff (!rstN)
    strobe.driveEn |-> (stageCnt <= lastIdx));
endmodule

// File: rtl/sweep_seq_ctrl.sv
module sweep_seq_ctrl
  import sweep_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       abortPulse,
  input  logic       resumePulse,
  input  logic       measDone,
  input  logic       lastStage,
  input  logic       lastPoint,
  input  logic       haltEach,
  input  logic       zeroPoints,
  output seqStrobe_t strobe,
  output logic       measStart,
  output logic       busy,
  output logic       haltFlag,
  output logic       sweepDone
);
  seqState_t state, nextState;
  logic finalMeas;

  assign finalMeas = lastStage && lastPoint;

  always_comb begin
    nextState       = state;
    strobe          = '0;
    strobe.driveEn  = (state == ST_ISSUE) || (state == ST_WAIT);
    unique case (state)
      ST_IDLE: if (startPulse) begin
        strobe.clearCnt = 1'b1;
        nextState = zeroPoints ? ST_IDLE : ST_ISSUE;
      end
      ST_ISSUE: nextState = ST_WAIT;
      ST_WAIT: if (measDone) begin
        strobe.advance = 1'b1;
        if (finalMeas)     nextState = ST_IDLE;
        else if (haltEach) nextState = ST_HALT;
        else               nextState = ST_ISSUE;
      end
      ST_HALT: if (resumePulse) nextState = ST_ISSUE;
      default: nextState = ST_IDLE;
    endcase
    if (abortPulse && state != ST_IDLE) begin
      nextState      = ST_IDLE;
      strobe.advance = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      sweepDone <= 1'b0;
    end else begin
      state <= nextState;
      if (strobe.clearCnt)
        sweepDone <= zeroPoints;
      else if (strobe.advance && finalMeas)
        sweepDone <= 1'b1;
    end
  end

  assign measStart = (state == ST_ISSUE);
  assign busy      = (state != ST_IDLE);
  assign haltFlag  = (state == ST_HALT);

  // R6: request is a single-cycle pulse
  a_r6_start_single: assert property (@(posedge clk) disable iff (!rstN)
    measStart |=> !measStart);
  // R9: abort empties the sweep without completion
  a_r9_abort_idle: assert property (@(posedge clk) disable iff (!rstN)
    (busy && abortPulse) |=> (!busy && !sweepDone));
  // R7: completion only while idle
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    sweepDone |-> !busy);
  // R8: halt holds until resume or abort
  a_r8_halt_hold: assert property (@(posedge clk) disable iff (!rstN)
    (haltFlag && !resumePulse && !abortPulse) |=> haltFlag);
  // R11: start during a running stage keeps the sweep alive
  a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (measStart && startPulse && !abortPulse) |=> busy);
endmodule

// File: rtl/sweep_stage_seq.sv
module sweep_stage_seq
  import sweep_seq_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 16,
  parameter int POINT_W     = 13,
  parameter int STAGE_W     = 3,
  parameter int SETUP_ADDR  = 6,
  parameter int POINTS_ADDR = 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       regWrEn,
  input  logic [ADDR_W-1:0]          regAddr,
  input  logic [DATA_W-1:0]          regWrData,
  input  logic                       startPulse,
  input  logic                       abortPulse,
  input  logic                       resumePulse,
  input  logic                       measDone,
  output logic                       measStart,
  output logic                       excitePort1,
  output logic                       excitePort2,
  output logic                       resultValid,
  output logic [STAGE_W+POINT_W-1:0] resultTag,
  output logic                       sweepBusy,
  output logic                       sweepHalted,
  output logic                       sweepDone
);
  seqStrobe_t strobe;
  logic lastStage, lastPoint, haltEach, zeroPoints;

  sweep_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .startPulse(startPulse), .abortPulse(abortPulse),
    .resumePulse(resumePulse), .measDone(measDone),
    .lastStage(lastStage), .lastPoint(lastPoint),
    .haltEach(haltEach), .zeroPoints(zeroPoints),
    .strobe(strobe), .measStart(measStart), .busy(sweepBusy),
    .haltFlag(sweepHalted), .sweepDone(sweepDone)
  );

  sweep_seq_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .POINT_W(POINT_W),
    .STAGE_W(STAGE_W), .SETUP_ADDR(SETUP_ADDR), .POINTS_ADDR(POINTS_ADDR)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .strobe(strobe), .lastStage(lastStage), .lastPoint(lastPoint),
    .haltEach(haltEach), .zeroPoints(zeroPoints),
    .excite1(excitePort1), .excite2(excitePort2),
    .resultValid(resultValid), .resultTag(resultTag)
  );

  // R5: no excitation unless a stage is running
  a_r5_quiet_when_parked: assert property (@(posedge clk) disable iff (!rstN)
    (!sweepBusy || sweepHalted) |-> (!excitePort1 && !excitePort2));
  // R4: never both ports at once
  a_r4_one_port: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({excitePort1, excitePort2}));
endmodule

// File: tb/sweep_stage_seq_bench.sv
module sweep_stage_seq_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [3:0] regAddr = '0;
  logic [15:0] regWrData = '0;
  logic startPulse = 1'b0, abortPulse = 1'b0, resumePulse = 1'b0, measDone = 1'b0;
  logic measStart, excitePort1, excitePort2, resultValid;
  logic [15:0] resultTag;
  logic sweepBusy, sweepHalted, sweepDone;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  sweep_stage_seq u_sweep_stage_seq (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .startPulse(startPulse), .abortPulse(abortPulse),
    .resumePulse(resumePulse), .measDone(measDone), .measStart(measStart),
    .excitePort1(excitePort1), .excitePort2(excitePort2),
    .resultValid(resultValid), .resultTag(resultTag), .sweepBusy(sweepBusy),
    .sweepHalted(sweepHalted), .sweepDone(sweepDone)
  );

  // {setup word, points}
  localparam logic [31:0] VEC [6] = '{
    {16'h0001, 16'd3},   // one stage, port 1 only
    {16'h2001, 16'd2},   // two stages, port 1 then port 2
    {16'h4010, 16'd2},   // three stages, port 2 first, port 1 last
    {16'h2009, 16'd1},   // both on stage 1: port 1 wins
    {16'h0028, 16'd2},   // port 1 index beyond the last stage
    {16'hE03E, 16'd1}    // eight stages
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk); regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic start();
    @(negedge clk); startPulse = 1'b1;
    @(negedge clk); startPulse = 1'b0;
  endtask

  // called while a stage is in flight; completes it and checks the tag
  task automatic doMeas(int s, int p, bit e1, bit e2, bit last);
    chk("R4 port1 select", 32'(excitePort1), 32'(e1));
    chk("R4 port2 select", 32'(excitePort2), 32'(e2));
    measDone = 1'b1;
    do @(negedge clk); while (!resultValid);
    measDone = 1'b0;
    chk("R3 tag", 32'(resultTag), 32'({s[2:0], p[12:0]}));
    chk("R7 busy after result", 32'(sweepBusy), 32'(!last));
    chk("R7 done after result", 32'(sweepDone), 32'(last));
    @(negedge clk);
    chk("R3 valid one cycle", 32'(resultValid), 32'd0);
  endtask

  task automatic runSweep(logic [15:0] setup, int pts);
    int sf = int'(setup[15:13]);
    int p1 = int'(setup[5:3]);
    int p2 = int'(setup[2:0]);
    bit hl = setup[12];
    for (int p = 0; p < pts; p++) begin
      for (int s = 0; s <= sf; s++) begin
        bit e1 = (s == p1);
        bit e2 = (s == p2) && !e1;
        bit last = (p == pts - 1) && (s == sf);
        doMeas(s, p, e1, e2, last);
        if (hl && !last) begin
          chk("R8 halted", 32'(sweepHalted), 32'd1);
          chk("R5 selects low halted", 32'({excitePort1, excitePort2}), 32'd0);
          @(negedge clk); resumePulse = 1'b1;
          @(negedge clk); resumePulse = 1'b0;
          chk("R8 resumed", 32'(sweepHalted), 32'd0);
        end
      end
    end
  endtask

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R5 reset selects", 32'({excitePort1, excitePort2}), 32'd0);
    chk("R7 reset busy/done", 32'({sweepBusy, sweepDone}), 32'd0);
    chk("R3 reset valid", 32'({resultValid, measStart}), 32'd0);

    // R1 R2 R4: table of sweeps
    foreach (VEC[i]) begin
      wr(4'h6, VEC[i][31:16]);
      wr(4'h1, VEC[i][15:0]);
      start();
      chk("R6 request after start", 32'(measStart), 32'd1);
      runSweep(VEC[i][31:16], int'(VEC[i][15:0]));
    end

    // R6: request is one cycle
    wr(4'h6, 16'h0001); wr(4'h1, 16'd1);
    start();
    chk("R6 request high", 32'(measStart), 32'd1);
    @(negedge clk);
    chk("R6 request single", 32'(measStart), 32'd0);
    // R8: resume outside halt ignored
    resumePulse = 1'b1; @(negedge clk); resumePulse = 1'b0;
    chk("R8 resume ignored", 32'({sweepBusy, resultValid, sweepHalted}), 32'b100);
    doMeas(0, 0, 1, 0, 1);

    // R7: zero points
    wr(4'h1, 16'd0);
    start();
    chk("R7 zero points done", 32'({sweepBusy, sweepDone, measStart}), 32'b010);

    // R8: halt per stage
    wr(4'h6, 16'h3001); wr(4'h1, 16'd2);
    start();
    chk("R7 done cleared by start", 32'(sweepDone), 32'd0);
    runSweep(16'h3001, 2);

    // R9: abort
    wr(4'h6, 16'h2001); wr(4'h1, 16'd4);
    start();
    doMeas(0, 0, 1, 0, 0);
    abortPulse = 1'b1; measDone = 1'b1;
    @(negedge clk); abortPulse = 1'b0; measDone = 1'b0;
    chk("R9 abort idle", 32'({sweepBusy, sweepDone}), 32'd0);
    chk("R9 abort no result", 32'(resultValid), 32'd0);
    chk("R9 abort selects", 32'({excitePort1, excitePort2}), 32'd0);

    // R10 and R11: writes and start during a sweep
    wr(4'h6, 16'h0001); wr(4'h1, 16'd2);
    start();
    doMeas(0, 0, 1, 0, 0);
    wr(4'h6, 16'h2008); wr(4'h1, 16'd5);
    start();                                 // R11 ignored
    doMeas(0, 1, 1, 0, 1);                   // R10 old config, R11 point 1
    start();
    runSweep(16'h2008, 5);                   // R10 new config in force

    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule